// File: doc/BRIEF.md
# Channel Wiper Code Register

This block keeps the wiper code of one digital-potentiometer channel and decides which tap the resistor decoder should select. It sits between the serial command decoder and the ladder decoder. Each accepted instruction comes in as a single-cycle strobe. The strobe carries a data code, an overwrite bit and a shutdown bit. The block also watches the lock status and the code held in the one-time fuses.

Before the fuses are locked, every instruction loads its data into the register. After locking, the fused code is in force. An instruction with its overwrite bit set may replace that code for the time being. The next instruction with the overwrite bit clear brings the fused code back. A reset clears the overwrite state. The preset loaded at reset depends on the lock status: midscale before locking, the fused code after.

Shutdown is shown on its own output flag. While shutdown is active, the stored code and the tap code keep their values, and writes are still taken in. Readback always returns the stored register.

Top module: `wiper_reg`

## Requirements
- R1: A reset applied while `locked` is 0 loads the midscale code, 1 << (CODE_W-1) (0x80 for 8 bits), into both `rd_code` and `tap_code`, and clears `sd_active`.
- R2: A reset applied while `locked` is 1 loads `fuse_code` into both `rd_code` and `tap_code`.
- R3: While `locked` is 0, a `wr_en` strobe loads `wr_data` into `rd_code` and `tap_code`. The values appear one cycle after the strobe edge, and any code value is accepted.
- R4: While `locked` is 1, a strobe with `ovr_bit` = 0 ignores `wr_data`. After it, `tap_code` and `rd_code` equal `fuse_code`.
- R5: While `locked` is 1, a strobe with `ovr_bit` = 1 loads `wr_data` into `rd_code` and `tap_code` one cycle after the strobe.
- R6: After an overwrite, a later strobe with `ovr_bit` = 0 returns `tap_code` and `rd_code` to `fuse_code`.
- R7: The overwrite state does not survive a reset. After a reset with `locked` = 1, the fused code is in force, and a strobe with `ovr_bit` = 0 leaves it in force.
- R8: `sd_active` takes the `sd_bit` of each strobe one cycle later. While it is 1, `tap_code` and `rd_code` still show the stored code. Without a strobe, all outputs hold.
- R9: Writes that arrive while shutdown is active are stored. The code last stored is the one in force after a strobe with `sd_bit` = 0 releases shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-on) |
| wr_en | input | 1 | Single-cycle instruction strobe |
| wr_data | input | CODE_W | Code carried by the instruction |
| ovr_bit | input | 1 | Overwrite bit of the instruction |
| sd_bit | input | 1 | Shutdown bit of the instruction |
| locked | input | 1 | Lock fuse blown |
| fuse_code | input | CODE_W | Code held in the data fuses |
| tap_code | output | CODE_W | Effective code to the ladder decoder |
| sd_active | output | 1 | Shutdown: wiper to low terminal, high terminal open |
| rd_code | output | CODE_W | Stored register value for readback |

## Verification
The bench checks that the reset preset follows the lock status. A design that always presets to midscale would show 0x80 instead of the fused code. It also checks that a locked write with the overwrite bit clear leaves the fused code in force, both right after an overwrite and right after a reset. A design that kept the overwrite flag across reset, or dropped the overwrite bit, would let the new data through. The last target is shutdown: the bench writes new codes while shut down and then releases shutdown. A design that forced the stored code to zero, or dropped writes during shutdown, would show a wrong code on readback or after the release.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

   // Midscale preset for a code of the given width
   function automatic logic [31:0] midscale(input int unsigned width);
      return 32'd1 << (width - 1);
   endfunction

   // Which source the effective tap follows
   typedef enum logic {
      SRC_STORED = 1'b0,
      SRC_FUSE   = 1'b1
   } tap_src_e;

   // Instruction fields that persist until the next instruction
   typedef struct packed {
      logic ovr;
      logic sd;
   } mode_t;

endpackage

// File: rtl/wiper_mode.sv
module wiper_mode (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 ovr_bit,
   input  logic                 sd_bit,
   input  logic                 locked,
   output wiper_pkg::mode_t     mode_q,
   output logic                 accept,
   output logic                 revert
);
   import wiper_pkg::*;

   mode_t mode_d;

   always_comb begin
      mode_d = mode_q;
      if (wr_en) begin
         mode_d.ovr = ovr_bit;
         mode_d.sd  = sd_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else begin
         mode_q <= mode_d;
      end
   end

   // Data load is allowed before locking, or with an explicit overwrite
   assign accept = wr_en && (!locked || ovr_bit);
   // Locked instruction without overwrite brings the fused code back
   assign revert = wr_en && locked && !ovr_bit;

endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
   parameter int unsigned CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic [CODE_W-1:0] fuse_code,
   input  logic              accept,
   input  logic              revert,
   input  logic [CODE_W-1:0] wr_data,
   output logic [CODE_W-1:0] stored_q
);
   import wiper_pkg::*;

   localparam logic [CODE_W-1:0] MID = CODE_W'(midscale(CODE_W));

   logic [CODE_W-1:0] preset;
   logic [CODE_W-1:0] next_q;

   assign preset = locked ? fuse_code : MID;

   always_comb begin
      next_q = stored_q;
      if (accept)      next_q = wr_data;
      else if (revert) next_q = fuse_code;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stored_q <= preset;
      end else begin
         stored_q <= next_q;
      end
   end

endmodule

// File: rtl/wiper_select.sv
module wiper_select #(
   parameter int unsigned CODE_W  = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              locked,
   input  logic              ovr_q,
   input  logic [CODE_W-1:0] fuse_code,
   input  logic [CODE_W-1:0] stored_q,
   output logic [CODE_W-1:0] tap_code
);
   import wiper_pkg::*;

   tap_src_e          src;
   logic [CODE_W-1:0] tap_c;

   assign src   = (locked && !ovr_q) ? SRC_FUSE : SRC_STORED;
   assign tap_c = (src == SRC_FUSE) ? fuse_code : stored_q;

   generate
      if (REG_OUT) begin : g_reg
         logic [CODE_W-1:0] tap_r;
         always_ff @(posedge clk) begin
            if (!rst_n) tap_r <= '0;
            else        tap_r <= tap_c;
         end
         assign tap_code = tap_r;
      end else begin : g_comb
         assign tap_code = tap_c;
      end
   endgenerate

endmodule

// File: rtl/wiper_reg.sv
module wiper_reg #(
   parameter int unsigned CODE_W  = 8,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_data,
   input  logic              ovr_bit,
   input  logic              sd_bit,
   input  logic              locked,
   input  logic [CODE_W-1:0] fuse_code,
   output logic [CODE_W-1:0] tap_code,
   output logic              sd_active,
   output logic [CODE_W-1:0] rd_code
);
   import wiper_pkg::*;

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
         $error("wiper_reg: CODE_W must be 2..16");
      end
   endgenerate

   mode_t             mode_q;
   logic              accept;
   logic              revert;
   logic [CODE_W-1:0] stored_q;

   wiper_mode u_mode (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .ovr_bit (ovr_bit),
      .sd_bit  (sd_bit),
      .locked  (locked),
      .mode_q  (mode_q),
      .accept  (accept),
      .revert  (revert)
   );

   wiper_store #(.CODE_W(CODE_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (locked),
      .fuse_code (fuse_code),
      .accept    (accept),
      .revert    (revert),
      .wr_data   (wr_data),
      .stored_q  (stored_q)
   );

   wiper_select #(.CODE_W(CODE_W), .REG_OUT(REG_OUT)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .locked    (locked),
      .ovr_q     (mode_q.ovr),
      .fuse_code (fuse_code),
      .stored_q  (stored_q),
      .tap_code  (tap_code)
   );

   assign sd_active = mode_q.sd;
   assign rd_code   = stored_q;

endmodule

// File: rtl/wiper_reg_chk.sv
module wiper_reg_chk #(
   parameter int unsigned CODE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [CODE_W-1:0] wr_data,
   input logic              ovr_bit,
   input logic              sd_bit,
   input logic              locked,
   input logic [CODE_W-1:0] fuse_code,
   input logic              sd_active,
   input logic [CODE_W-1:0] rd_code
);
   localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

   // R1 and R2: the preset follows the lock status seen during reset
   p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> rd_code == ($past(locked) ? $past(fuse_code) : MID));

   // R3 and R5: an accepted write lands in the register
   p_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_en) && (!$past(locked) || $past(ovr_bit))
      |-> rd_code == $past(wr_data));

   // R4 and R6: a locked write without overwrite restores the fused code
   p_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_en) && $past(locked) && !$past(ovr_bit)
      |-> rd_code == $past(fuse_code));

   // R8: shutdown follows the latest instruction
   p_sd_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(wr_en) |-> sd_active == $past(sd_bit));

   // R8: without an instruction, the state holds
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && !$past(wr_en) |-> $stable(rd_code) && $stable(sd_active));

endmodule

bind wiper_reg wiper_reg_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .ovr_bit   (ovr_bit),
   .sd_bit    (sd_bit),
   .locked    (locked),
   .fuse_code (fuse_code),
   .sd_active (sd_active),
   .rd_code   (rd_code)
);

// File: tb/tb_wiper_reg.sv
module tb_wiper_reg;
   localparam int CLK_PERIOD = 10;
   localparam int W = 8;
   localparam int NVEC = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic         ovr_bit = 1'b0;
   logic         sd_bit = 1'b0;
   logic         locked = 1'b0;
   logic [W-1:0] fuse_code = 8'h3C;
   logic [W-1:0] tap_code;
   logic         sd_active;
   logic [W-1:0] rd_code;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wiper_reg dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ovr_bit(ovr_bit), .sd_bit(sd_bit), .locked(locked),
      .fuse_code(fuse_code), .tap_code(tap_code),
      .sd_active(sd_active), .rd_code(rd_code)
   );

   // {locked, wr_en, ovr, sd, data, exp_tap, exp_rd, exp_sd}; fuse is 0x3C
   localparam logic [28:0] VEC [NVEC] = '{
      {1'b0,1'b1,1'b0,1'b0,8'h11,8'h11,8'h11,1'b0},  // R3
      {1'b0,1'b1,1'b0,1'b0,8'hFF,8'hFF,8'hFF,1'b0},  // R3
      {1'b0,1'b1,1'b0,1'b0,8'h00,8'h00,8'h00,1'b0},  // R3
      {1'b1,1'b1,1'b0,1'b0,8'h55,8'h3C,8'h3C,1'b0},  // R4
      {1'b1,1'b1,1'b1,1'b0,8'h99,8'h99,8'h99,1'b0},  // R5
      {1'b1,1'b1,1'b0,1'b0,8'hAA,8'h3C,8'h3C,1'b0},  // R6
      {1'b1,1'b1,1'b1,1'b1,8'h42,8'h42,8'h42,1'b1},  // R8
      {1'b1,1'b1,1'b1,1'b1,8'h43,8'h43,8'h43,1'b1},  // R9
      {1'b1,1'b1,1'b1,1'b0,8'h44,8'h44,8'h44,1'b0},  // R9
      {1'b1,1'b0,1'b0,1'b1,8'hEE,8'h44,8'h44,1'b0}   // R8
   };

   task automatic check(input string req, input logic [W-1:0] et,
                        input logic [W-1:0] er, input logic es);
      n_checks++;
      if (tap_code !== et || rd_code !== er || sd_active !== es) begin
         n_fail++;
         $display("FAIL %s: tap=%h rd=%h sd=%b expected tap=%h rd=%h sd=%b",
                  req, tap_code, rd_code, sd_active, et, er, es);
      end
   endtask

   // Drive at negedge, strobe one edge, sample at the following negedge
   task automatic instr(input logic l, input logic w, input logic o,
                        input logic s, input logic [W-1:0] d);
      locked = l; wr_en = w; ovr_bit = o; sd_bit = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset(input logic l);
      locked = l; wr_en = 1'b0; rst_n = 1'b0;
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(1'b0);
      check("R1", 8'h80, 8'h80, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         instr(VEC[i][28], VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:17]);
         check($sformatf("vector %0d", i), VEC[i][16:9], VEC[i][8:1], VEC[i][0]);
      end

      // R2 and R7: reset while locked, overwrite forgotten
      do_reset(1'b1);
      check("R2", 8'h3C, 8'h3C, 1'b0);
      instr(1'b1, 1'b1, 1'b0, 1'b0, 8'h77);
      check("R7", 8'h3C, 8'h3C, 1'b0);

      // R1 again after a locked run; unlocked shutdown with write
      do_reset(1'b0);
      check("R1", 8'h80, 8'h80, 1'b0);
      instr(1'b0, 1'b1, 1'b0, 1'b1, 8'h21);
      check("R8", 8'h21, 8'h21, 1'b1);
      instr(1'b0, 1'b1, 1'b0, 1'b1, 8'hFE);
      check("R9", 8'hFE, 8'hFE, 1'b1);
      instr(1'b0, 1'b1, 1'b0, 1'b0, 8'h01);
      check("R9", 8'h01, 8'h01, 1'b0);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule